// File: doc/BRIEF.md
# Converter Start-up Sequencer

This block brings the digital core of a stereo oversampling converter out of reset in a controlled order. It takes a master clock and an asynchronous active-low reset. It divides the master clock down to a modulator-rate enable at 64 times the frame rate and marks each frame. It then runs a fixed-length offset-calibration window before it declares the converter running. While the core is held, the block drives a clear level for the decimator and output buffer. It also raises a forcing control that pins the data outputs low, and it parks the bit-clock output at a configured level.

The master clock runs at either 256 or 384 times the frame rate, and a ratio input chooses between them. In master mode, the frame clock and bit clock are generated here from the master clock, and calibration starts as soon as the synchronised reset lifts. In slave mode, the block stays completely static until the external frame clock shows a qualifying edge pattern. That pattern is either a falling edge followed by a rising edge, or a three-step word-clock/frame-clock handshake. The calibration window starts only after that pattern. Configuration inputs are captured only while reset is held.

Top module: `cnv_start_seq`

## Requirements
- R1: Driving `rst_n_async` low raises `dec_clear` at once, without waiting for a clock edge. After `rst_n_async` rises, `dec_clear` stays high through the first rising `mclk` edge and falls after the second one. The cycle after that second edge is the first active cycle in master mode.
- R2: While the synchronised reset is held, the outputs take fixed values:
  - `force_low` is 1.
  - `mod_en`, `frame_stb`, `cal_active`, `running` and `lrck_out` are 0.
  - `bclk_out` equals `rd_edge_cfg`.
- R3: Once active, `mod_en` is high for one cycle in every 4 `mclk` cycles when `ratio_sel`=0, or in every 6 when `ratio_sel`=1. The first pulse falls in the first active cycle.
- R4: `frame_stb` is high for one cycle every 64 modulator periods, which is 256 or 384 `mclk` cycles. It always coincides with a `mod_en` pulse, and the first one falls in the first active cycle.
- R5: In master mode (`slave_sel`=0), `lrck_out` is high for the first half of each frame and `bclk_out` is high for the first half of each modulator period. In slave mode, they stay at 0 and at `rd_edge_cfg` respectively.
- R6: In slave mode with `wclk_pos_sel`=0, every output stays at its idle value until `lrck_in` has fallen and then risen. A rise with no earlier fall does not count. The first active cycle follows the second rising `mclk` edge after the qualifying rise of `lrck_in`.
- R7: In slave mode with `wclk_pos_sel`=1, activation needs three conditions, seen in this order:
  - first, `wclk_in`=1 with `lrck_in`=1;
  - then `wclk_in`=1 with `lrck_in`=0;
  - then `wclk_in`=1 with `lrck_in`=1.

  Out-of-order conditions, and conditions with `wclk_in`=0, do not advance the sequence. Activation latency is as in R6, counted from the completing condition.
- R8: `cal_active` is high for exactly the first CAL_FRAMES frames after activation and falls on a frame boundary.
- R9: `running` rises on the frame boundary one frame after calibration ends, which is (CAL_FRAMES+1) frames after activation. `force_low` falls in the same cycle.
- R10: `ratio_sel`, `slave_sel` and `wclk_pos_sel` are sampled only while reset is held. Changing them while active has no effect on any output.
- R11: Two instances sharing `mclk` and `rst_n_async` produce identical outputs on every cycle when reset is released on a falling `mclk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, 256x or 384x frame rate |
| rst_n_async | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 1 | 1 = 384x master clock, 0 = 256x |
| slave_sel | input | 1 | 1 = slave mode, 0 = master mode |
| wclk_pos_sel | input | 1 | 1 = slave start needs word-clock handshake |
| rd_edge_cfg | input | 1 | Idle level for the bit-clock output |
| lrck_in | input | 1 | External frame clock (slave mode) |
| wclk_in | input | 1 | External word clock (slave mode) |
| mod_en | output | 1 | Modulator-rate clock enable (64x frame rate) |
| frame_stb | output | 1 | One-cycle strobe at the start of each frame |
| dec_clear | output | 1 | Clear for decimator and output buffer |
| force_low | output | 1 | Holds the data outputs low |
| bclk_out | output | 1 | Generated bit clock (master) or idle level |
| lrck_out | output | 1 | Generated frame clock (master) or 0 |
| cal_active | output | 1 | Calibration window in progress |
| running | output | 1 | Normal conversion running |

## Verification
The bench builds the block with CAL_FRAMES=3 instead of 8192. This shrinks the calibration window to a few hundred cycles, so the whole path from reset to `running` fits in every sweep. With it, the bench compares every output against arithmetic expectations on each cycle of the complete start-up, for both clock ratios and for both slave start variants. The divider constants keep their defaults, so frame lengths of 256 and 384 cycles are checked exactly.

// File: rtl/cnv_seq_pkg.sv
// Shared types for the converter start-up sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package cnv_seq_pkg;

    // Calibration/run phases after activation.
    typedef enum logic [1:0] {
        CS_CAL    = 2'd0,
        CS_SETTLE = 2'd1,
        CS_RUN    = 2'd2
    } cal_state_t;

    // Slave start qualification progress.
    typedef enum logic [1:0] {
        GS_STEP_A = 2'd0,
        GS_STEP_B = 2'd1,
        GS_STEP_C = 2'd2,
        GS_GO     = 2'd3
    } gate_state_t;

endpackage

// File: rtl/cnv_rst_sync.sv
// Reset synchroniser: asserts asynchronously, releases after STAGES
// rising clock edges. Assumes STAGES >= 1.
module cnv_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop: set on each edge, clear asynchronously.
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain <= 1'b0;
                else         chain <= 1'b1;
            end
        end else begin : g_chain
            // Shift a one through the chain, clear all asynchronously.
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain <= '0;
                else         chain <= {chain[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign srst_n = chain[STAGES-1];

endmodule

// File: rtl/cnv_clk_div.sv
// Divides the master clock into modulator periods and frames.
// Assumes: ratio_hi is stable while run_en is high; DIV_LO/DIV_HI even.
module cnv_clk_div #(
    parameter int DIV_LO        = 4,
    parameter int DIV_HI        = 6,
    parameter int MOD_PER_FRAME = 64,
    localparam int DIV_W        = $clog2(DIV_HI),
    localparam int SLOT_W       = $clog2(MOD_PER_FRAME)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic ratio_hi,
    output logic mod_en,
    output logic frame_stb,
    output logic frame_end,
    output logic bit_phase,
    output logic frame_phase
);

    logic [DIV_W-1:0]  div_cnt;
    logic [SLOT_W-1:0] slot_cnt;
    logic [DIV_W-1:0]  div_last;
    logic [DIV_W-1:0]  div_half;
    logic              div_wrap;
    logic              slot_wrap;

    // Select the terminal count and half point for the current ratio.
    always_comb begin
        div_last = ratio_hi ? DIV_W'(DIV_HI - 1) : DIV_W'(DIV_LO - 1);
        div_half = ratio_hi ? DIV_W'(DIV_HI / 2) : DIV_W'(DIV_LO / 2);
    end

    assign div_wrap  = (div_cnt == div_last);
    assign slot_wrap = (slot_cnt == SLOT_W'(MOD_PER_FRAME - 1));

    // Count master clocks within a modulator period and periods in a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            div_cnt  <= '0;
            slot_cnt <= '0;
        end else if (div_wrap) begin
            div_cnt  <= '0;
            slot_cnt <= slot_wrap ? '0 : slot_cnt + 1'b1;
        end else begin
            div_cnt  <= div_cnt + 1'b1;
        end
    end

    assign mod_en      = run_en && (div_cnt == '0);
    assign frame_stb   = mod_en && (slot_cnt == '0);
    assign frame_end   = run_en && div_wrap && slot_wrap;
    assign bit_phase   = div_cnt < div_half;
    assign frame_phase = slot_cnt < SLOT_W'(MOD_PER_FRAME / 2);

endmodule

// File: rtl/cnv_slave_gate.sv
// Qualifies slave-mode start from the external frame and word clocks.
// Plain variant: frame clock fall, then rise. Handshake variant: three
// word/frame clock conditions in order. Assumes inputs share the master
// clock's source, so one register stage suffices.
module cnv_slave_gate
    import cnv_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hs_mode,
    input  logic lrck_in,
    input  logic wclk_in,
    output logic started
);

    gate_state_t st, st_nx;
    logic l_q, l_p, w_q;
    logic l_fall, l_rise, cond_hh, cond_hl;

    // Register the external clocks; preload history during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q <= lrck_in;
            l_p <= lrck_in;
            w_q <= wclk_in;
        end else begin
            l_q <= lrck_in;
            l_p <= l_q;
            w_q <= wclk_in;
        end
    end

    assign l_fall  = l_p && !l_q;
    assign l_rise  = !l_p && l_q;
    assign cond_hh = w_q && l_q;
    assign cond_hl = w_q && !l_q;

    // Advance the qualification sequence for the selected variant.
    always_comb begin
        st_nx = st;
        unique case (st)
            GS_STEP_A: if (hs_mode ? cond_hh : l_fall) st_nx = GS_STEP_B;
            GS_STEP_B: begin
                if (hs_mode) begin
                    if (cond_hl) st_nx = GS_STEP_C;
                end else if (l_rise) begin
                    st_nx = GS_GO;
                end
            end
            GS_STEP_C: if (cond_hh) st_nx = GS_GO;
            GS_GO:     st_nx = GS_GO;
            default:   st_nx = GS_STEP_A;
        endcase
    end

    // Hold the sequence state.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= GS_STEP_A;
        else        st <= st_nx;
    end

    assign started = (st == GS_GO);

endmodule

// File: rtl/cnv_cal_fsm.sv
// Times the calibration window in frames, then one settle frame, then run.
// Assumes frame_end pulses once per frame while active is high.
module cnv_cal_fsm
    import cnv_seq_pkg::*;
#(
    parameter int CAL_FRAMES = 8192,
    localparam int CNT_W     = $clog2(CAL_FRAMES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic frame_end,
    output logic cal_active,
    output logic running
);

    cal_state_t      st;
    logic [CNT_W-1:0] frame_cnt;

    // Count frames in the window and step through the phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= CS_CAL;
            frame_cnt <= '0;
        end else if (active && frame_end) begin
            unique case (st)
                CS_CAL: begin
                    if (frame_cnt == CNT_W'(CAL_FRAMES - 1)) st <= CS_SETTLE;
                    else frame_cnt <= frame_cnt + 1'b1;
                end
                CS_SETTLE: st <= CS_RUN;
                CS_RUN:    st <= CS_RUN;
                default:   st <= CS_CAL;
            endcase
        end
    end

    assign cal_active = active && (st == CS_CAL);
    assign running    = rst_n && (st == CS_RUN);

endmodule

// File: rtl/cnv_start_seq.sv
// Converter start-up sequencer top. Synchronises reset, captures the
// configuration during reset, gates activation by mode, and drives the
// modulator enable, frame strobe, clocks, clear/force and status flags.
// Assumes external frame/word clocks derive from the master clock source.
module cnv_start_seq #(
    parameter int CAL_FRAMES    = 8192,
    parameter int DIV_LO        = 4,
    parameter int DIV_HI        = 6,
    parameter int MOD_PER_FRAME = 64,
    parameter int SYNC_STAGES   = 2
) (
    input  logic mclk,
    input  logic rst_n_async,
    input  logic ratio_sel,
    input  logic slave_sel,
    input  logic wclk_pos_sel,
    input  logic rd_edge_cfg,
    input  logic lrck_in,
    input  logic wclk_in,
    output logic mod_en,
    output logic frame_stb,
    output logic dec_clear,
    output logic force_low,
    output logic bclk_out,
    output logic lrck_out,
    output logic cal_active,
    output logic running
);

    logic rst_n_s;
    logic ratio_q, slave_q, hs_q;
    logic slave_started, active;
    logic frame_end, bit_phase, frame_phase;
    logic gen_clocks;

    cnv_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (mclk),
        .arst_n (rst_n_async),
        .srst_n (rst_n_s)
    );

    // Capture configuration only while reset is held.
    always_ff @(posedge mclk) begin
        if (!rst_n_s) begin
            ratio_q <= ratio_sel;
            slave_q <= slave_sel;
            hs_q    <= wclk_pos_sel;
        end
    end

    cnv_slave_gate u_gate (
        .clk     (mclk),
        .rst_n   (rst_n_s),
        .hs_mode (hs_q),
        .lrck_in (lrck_in),
        .wclk_in (wclk_in),
        .started (slave_started)
    );

    assign active = rst_n_s && (slave_q ? slave_started : 1'b1);

    cnv_clk_div #(
        .DIV_LO        (DIV_LO),
        .DIV_HI        (DIV_HI),
        .MOD_PER_FRAME (MOD_PER_FRAME)
    ) u_div (
        .clk         (mclk),
        .rst_n       (rst_n_s),
        .run_en      (active),
        .ratio_hi    (ratio_q),
        .mod_en      (mod_en),
        .frame_stb   (frame_stb),
        .frame_end   (frame_end),
        .bit_phase   (bit_phase),
        .frame_phase (frame_phase)
    );

    cnv_cal_fsm #(.CAL_FRAMES(CAL_FRAMES)) u_cal (
        .clk        (mclk),
        .rst_n      (rst_n_s),
        .active     (active),
        .frame_end  (frame_end),
        .cal_active (cal_active),
        .running    (running)
    );

    assign gen_clocks = active && !slave_q;
    assign dec_clear  = !rst_n_s;
    assign force_low  = !rst_n_s || !running;
    assign bclk_out   = gen_clocks ? bit_phase : rd_edge_cfg;
    assign lrck_out   = gen_clocks && frame_phase;

endmodule

// File: rtl/cnv_start_seq_chk.sv
// Property checker for the start-up sequencer, bound into the top.
module cnv_start_seq_chk (
    input logic clk,
    input logic rst_n_s,
    input logic mod_en,
    input logic frame_stb,
    input logic force_low,
    input logic cal_active,
    input logic running,
    input logic lrck_out
);

    // R2: idle outputs while the synchronised reset is held.
    always @(posedge clk) begin
        if (rst_n_s === 1'b0) begin
            p_idle_in_reset_r2: assert (force_low && !mod_en && !frame_stb
                                        && !cal_active && !running && !lrck_out)
                else $error("idle output violated in reset");
        end
    end

    // R3: modulator enable never pulses on adjacent cycles.
    p_mod_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
        mod_en |=> !mod_en);

    // R4: frame strobe coincides with a modulator pulse.
    p_stb_on_mod_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
        frame_stb |-> mod_en);

    // R8: calibration ends on a frame boundary.
    p_cal_end_frame_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
        $fell(cal_active) |-> frame_stb);

    // R8: calibration and running never overlap.
    p_cal_run_excl_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
        !(cal_active && running));

    // R9: running begins on a frame boundary and then persists.
    p_run_start_frame_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
        $rose(running) |-> frame_stb);

    p_run_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
        running |=> running);

endmodule

bind cnv_start_seq cnv_start_seq_chk u_chk (
    .clk        (mclk),
    .rst_n_s    (rst_n_s),
    .mod_en     (mod_en),
    .frame_stb  (frame_stb),
    .force_low  (force_low),
    .cal_active (cal_active),
    .running    (running),
    .lrck_out   (lrck_out)
);

// File: tb/sim_cnv_start_seq.sv
`timescale 1ns/1ps
module sim_cnv_start_seq;

    localparam int NCAL = 3;

    logic mclk = 1'b0;
    logic rst_n_async = 1'b0;
    logic ratio_sel = 1'b0, slave_sel = 1'b0, wclk_pos_sel = 1'b0;
    logic rd_edge_cfg = 1'b0, lrck_in = 1'b0, wclk_in = 1'b0;

    logic mod_en, frame_stb, dec_clear, force_low, bclk_out, lrck_out, cal_active, running;
    logic mod_en1, frame_stb1, dec_clear1, force_low1, bclk_out1, lrck_out1, cal_active1, running1;

    int checks = 0;
    int failures = 0;

    always #4 mclk = ~mclk;

    cnv_start_seq #(.CAL_FRAMES(NCAL)) u0 (
        .mclk(mclk), .rst_n_async(rst_n_async), .ratio_sel(ratio_sel),
        .slave_sel(slave_sel), .wclk_pos_sel(wclk_pos_sel), .rd_edge_cfg(rd_edge_cfg),
        .lrck_in(lrck_in), .wclk_in(wclk_in), .mod_en(mod_en), .frame_stb(frame_stb),
        .dec_clear(dec_clear), .force_low(force_low), .bclk_out(bclk_out),
        .lrck_out(lrck_out), .cal_active(cal_active), .running(running));

    cnv_start_seq #(.CAL_FRAMES(NCAL)) u1 (
        .mclk(mclk), .rst_n_async(rst_n_async), .ratio_sel(ratio_sel),
        .slave_sel(slave_sel), .wclk_pos_sel(wclk_pos_sel), .rd_edge_cfg(rd_edge_cfg),
        .lrck_in(lrck_in), .wclk_in(wclk_in), .mod_en(mod_en1), .frame_stb(frame_stb1),
        .dec_clear(dec_clear1), .force_low(force_low1), .bclk_out(bclk_out1),
        .lrck_out(lrck_out1), .cal_active(cal_active1), .running(running1));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] outs0();
        return {mod_en, frame_stb, dec_clear, force_low, bclk_out, lrck_out, cal_active, running};
    endfunction

    function automatic logic [7:0] outs1();
        return {mod_en1, frame_stb1, dec_clear1, force_low1, bclk_out1, lrck_out1, cal_active1, running1};
    endfunction

    // Outputs expected while idle (reset or slave wait); R2 / R6 / R7.
    task automatic idle_chk(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge mclk);
            chk(outs0() == {2'b00, dec_clear, 1'b1, rd_edge_cfg, 3'b000}, tag,
                outs0(), {2'b00, dec_clear, 1'b1, rd_edge_cfg, 3'b000});
        end
    endtask

    // Assert reset, check it, load configuration, release on a falling edge.
    task automatic do_reset(input bit rat, input bit slv, input bit hs);
        @(negedge mclk);
        rst_n_async = 1'b0;
        #1;
        chk(dec_clear == 1'b1, "R1 immediate clear", dec_clear, 1);
        ratio_sel = rat; slave_sel = slv; wclk_pos_sel = hs;
        lrck_in = 1'b0; wclk_in = 1'b0;
        rd_edge_cfg = 1'b1;
        idle_chk(3, "R2 reset idle rde=1");
        rd_edge_cfg = 1'b0;
        idle_chk(3, "R2 reset idle rde=0");
        chk(dec_clear == 1'b1, "R2 clear held", dec_clear, 1);
        @(negedge mclk);
        rst_n_async = 1'b1;
        @(negedge mclk);
        chk(dec_clear == 1'b1, "R1 clear after one edge", dec_clear, 1);
    endtask

    // Per-cycle sweep from the first active cycle (current negedge = t 0).
    task automatic sweep(input int d, input bit master, input int ncyc, input int flip_at);
        int f;
        f = 64 * d;
        for (int t = 0; t < ncyc; t++) begin
            if (t == flip_at) begin
                ratio_sel = ~ratio_sel; slave_sel = ~slave_sel; wclk_pos_sel = ~wclk_pos_sel;
            end
            chk(dec_clear == 1'b0, "R1 clear released", dec_clear, 0);
            chk(mod_en == ((t % d) == 0), "R3/R10 mod_en", mod_en, int'((t % d) == 0));
            chk(frame_stb == ((t % f) == 0), "R4 frame_stb", frame_stb, int'((t % f) == 0));
            chk(cal_active == (t < NCAL * f), "R8 cal_active", cal_active, int'(t < NCAL * f));
            chk(running == (t >= (NCAL + 1) * f), "R9 running", running, int'(t >= (NCAL + 1) * f));
            chk(force_low == (t < (NCAL + 1) * f), "R9 force_low", force_low, int'(t < (NCAL + 1) * f));
            if (master) begin
                chk(bclk_out == ((t % d) < d / 2), "R5 bclk_out", bclk_out, int'((t % d) < d / 2));
                chk(lrck_out == ((t % f) < f / 2), "R5 lrck_out", lrck_out, int'((t % f) < f / 2));
            end else begin
                chk(bclk_out == rd_edge_cfg, "R5 slave bclk", bclk_out, rd_edge_cfg);
                chk(lrck_out == 1'b0, "R5 slave lrck", lrck_out, 0);
            end
            chk(outs1() == outs0(), "R11 instances match", outs1(), outs0());
            @(negedge mclk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge mclk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // Master, 256x; config flipped mid-run must not matter (R10).
        do_reset(1'b0, 1'b0, 1'b0);
        @(negedge mclk);
        sweep(4, 1'b1, (NCAL + 2) * 256, 50);

        // Master, 384x.
        do_reset(1'b1, 1'b0, 1'b0);
        @(negedge mclk);
        sweep(6, 1'b1, (NCAL + 2) * 384, -1);

        // Slave plain start (R6): rise without a prior fall is ignored.
        do_reset(1'b0, 1'b1, 1'b0);
        idle_chk(20, "R6 slave idle after reset");
        lrck_in = 1'b1;
        idle_chk(10, "R6 rise without fall ignored");
        lrck_in = 1'b0;
        idle_chk(10, "R6 fall alone not enough");
        lrck_in = 1'b1;
        idle_chk(1, "R6 one edge after rise");
        @(negedge mclk);
        sweep(4, 1'b0, (NCAL + 2) * 256, -1);

        // Slave handshake start (R7), 384x.
        do_reset(1'b1, 1'b1, 1'b1);
        wclk_in = 1'b1;
        idle_chk(5, "R7 out-of-order condition ignored");
        lrck_in = 1'b1;
        idle_chk(5, "R7 after step one");
        lrck_in = 1'b0;
        idle_chk(5, "R7 after step two");
        wclk_in = 1'b0; lrck_in = 1'b1;
        idle_chk(5, "R7 word clock low blocks step three");
        wclk_in = 1'b1;
        idle_chk(1, "R7 one edge after completion");
        @(negedge mclk);
        sweep(6, 1'b0, (NCAL + 2) * 384, -1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule